// File: doc/BRIEF.md
# Extension Operation Execution Controller

This block sequences one extension operation at a time on a compute unit attached to a host core. When the core issues an operation, the block presents the operation slot to an external descriptor table and latches the descriptor that comes back in the same cycle. It then pulses a start strobe to the compute unit. It holds the core stall line either for a declared number of cycles or until the unit reports completion. It masks the core's interrupt line when the descriptor asks for it. When the operation ends it updates a small status register.

The block also owns the single data-memory port. While an operation is running, the compute unit drives its own address and write data onto that port and receives the read data directly. In the normal mode the core is stalled for the whole operation, so the port belongs to the unit alone. In concurrent mode the core keeps running, and it is stalled only in a cycle where both sides request the port. The unit wins that cycle.

The descriptor is 11 bits wide: bit 0 is latency-valid, bits 8:1 are the latency, bit 9 is interrupt-block and bit 10 is concurrent. The status port is 3 bits wide: bit 0 is busy, bit 1 is done and bit 2 is error.

Top module: `ext_op_exec_ctrl`

## Requirements
- R1: An issue is accepted only when the controller is idle. In the cycle after acceptance `cu_start_o` is high for exactly one cycle. An issue presented while an operation is running, or in its finishing cycle, has no effect on stall length or status.
- R2: With latency-valid set (descriptor bit 0) and concurrent clear (bit 10), `core_stall_o` is high for exactly max(L,1) consecutive cycles, starting the cycle after issue. L is descriptor bits 8:1, so a latency of 0 completes in the cycle after issue.
- R3: With latency-valid clear, `core_stall_o` is high from the cycle after issue up to and including the cycle in which `cu_done_i` is sampled high. It is low in the next cycle.
- R4: `irq_core_o` follows `irq_req_i`, except while an operation with interrupt-block (bit 9) set is running, when it is 0. The mask is released in the finishing cycle.
- R5: Status busy (bit 0) is 1 and done (bit 1) is 0 from the cycle after issue. In the cycle after the last running cycle, busy is 0 and done is 1. Done stays set until the next accepted issue.
- R6: `cu_done_i` sampled high while idle sets status error (bit 2) from the next cycle. Error stays set until the next accepted issue clears it. A completion pulse during an operation does not set error.
- R7: In concurrent mode the core is not stalled for the operation. In a running cycle where both `core_mem_req_i` and `cu_mem_req_i` are high, `core_stall_o` is high and the unit is granted. A fixed-latency concurrent operation still sets done after max(L,1) running cycles.
- R8: While an operation is running, a unit request is granted and drives the memory address, write enable and write data. `cu_mem_rdata_o` equals `mem_rdata_i`. In non-concurrent mode the core gets no grant while the operation runs. When no operation is running, unit requests are refused and core requests are granted.
- R9: `desc_slot_o` equals `issue_slot_i` in every cycle, so the descriptor can be looked up in the issue cycle.
- R10: After reset the controller is idle: stall low, start low, status 0, and interrupts pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | Issue request from the core |
| issue_slot_i | input | SLOT_W | Operation slot of the issued operation |
| desc_slot_o | output | SLOT_W | Slot index sent to the descriptor table |
| desc_i | input | 11 | Descriptor returned by the table |
| cu_start_o | output | 1 | One-cycle start strobe to the compute unit |
| cu_done_i | input | 1 | Completion pulse from the compute unit |
| core_stall_o | output | 1 | Stall to the core |
| irq_req_i | input | 1 | Interrupt request toward the core |
| irq_core_o | output | 1 | Interrupt after masking |
| status_o | output | 3 | {error, done, busy} |
| core_mem_req_i | input | 1 | Core memory request |
| core_mem_we_i | input | 1 | Core write enable |
| core_mem_addr_i | input | ADDR_W | Core address |
| core_mem_wdata_i | input | DATA_W | Core write data |
| core_mem_gnt_o | output | 1 | Core granted this cycle |
| core_mem_rdata_o | output | DATA_W | Read data to the core |
| cu_mem_req_i | input | 1 | Unit memory request |
| cu_mem_we_i | input | 1 | Unit write enable |
| cu_mem_addr_i | input | ADDR_W | Unit address |
| cu_mem_wdata_i | input | DATA_W | Unit write data |
| cu_mem_gnt_o | output | 1 | Unit granted this cycle |
| cu_mem_rdata_o | output | DATA_W | Read data to the unit |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_rdata_i | input | DATA_W | Memory read data |

## Verification
The two functions that can meet in one cycle are the concurrent-mode operation, which lets the core run, and the core's own memory traffic. The collision is provoked by raising both the core and the unit memory requests in a running cycle of a concurrent operation. It is judged by a stall in that same cycle, a grant to the unit only and the unit's address on the memory port. In the cycle after, with only the core requesting, the bench expects no stall and the core's address on the port. A second overlap is a new issue arriving while an operation runs or finishes; it is judged by the unchanged stall count and the idle status afterwards.

// File: rtl/ext_exec_pkg.sv
package ext_exec_pkg;

    parameter int LAT_W = 8;

    // Descriptor: bit 0 latency valid, bits LAT_W:1 latency, then irq block, then concurrent.
    typedef struct packed {
        logic             concurrent;
        logic             irq_block;
        logic [LAT_W-1:0] latency;
        logic             lat_valid;
    } op_desc_t;

    localparam int DESC_W = $bits(op_desc_t);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_START  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_FINISH = 2'd3
    } exec_state_t;

    // Status: bit 0 busy, bit 1 done, bit 2 error.
    typedef struct packed {
        logic error;
        logic done;
        logic busy;
    } op_status_t;

    // A running count of 0 or 1 means the current cycle is the last stalled one.
    function automatic logic count_expired(input logic [LAT_W-1:0] c);
        return c <= LAT_W'(1);
    endfunction

endpackage

// File: rtl/ext_exec_seq.sv
module ext_exec_seq
    import ext_exec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        issue_i,
    input  op_desc_t    desc_i,
    input  logic        cu_done_i,
    output exec_state_t state_o,
    output op_desc_t    desc_o,
    output logic        issue_acc_o,
    output logic        complete_o,
    output logic        cu_start_o
);

    exec_state_t      state_q, state_d;
    op_desc_t         desc_q;
    logic [LAT_W-1:0] cnt_q, cnt_d;
    logic             running;

    assign issue_acc_o = (state_q == ST_IDLE) && issue_i;
    assign running     = (state_q == ST_START) || (state_q == ST_WAIT);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (issue_i) begin
                    state_d = ST_START;
                    cnt_d   = desc_i.latency;
                end
            end
            ST_START, ST_WAIT: begin
                if (desc_q.lat_valid) begin
                    if (count_expired(cnt_q)) begin
                        state_d = ST_FINISH;
                    end else begin
                        state_d = ST_WAIT;
                        cnt_d   = cnt_q - LAT_W'(1);
                    end
                end else begin
                    state_d = cu_done_i ? ST_FINISH : ST_WAIT;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            desc_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (issue_acc_o) desc_q <= desc_i;
        end
    end

    assign complete_o = running && (state_d == ST_FINISH);
    assign cu_start_o = (state_q == ST_START);
    assign state_o    = state_q;
    assign desc_o     = desc_q;

    // R1: the start strobe lasts a single cycle
    a_r1_start_single: assert property (@(posedge clk) disable iff (rst)
        cu_start_o |=> !cu_start_o);

    // R1: the finishing cycle always returns to idle
    a_r1_finish_to_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FINISH) |=> (state_q == ST_IDLE));

    // R3: a handshake operation keeps waiting until completion is seen
    a_r3_hold_wait: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && !desc_q.lat_valid && !cu_done_i) |=> (state_q == ST_WAIT));

endmodule

// File: rtl/ext_exec_status.sv
module ext_exec_status
    import ext_exec_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       issue_acc_i,
    input  logic       complete_i,
    input  logic       idle_i,
    input  logic       cu_done_i,
    output op_status_t status_o
);

    op_status_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            if (issue_acc_i) begin
                st_q.busy <= 1'b1;
                st_q.done <= 1'b0;
            end else if (complete_i) begin
                st_q.busy <= 1'b0;
                st_q.done <= 1'b1;
            end
            st_q.error <= (st_q.error && !issue_acc_i) || (idle_i && cu_done_i);
        end
    end

    assign status_o = st_q;

    // R5: completion leaves done set and busy clear
    a_r5_done_after_complete: assert property (@(posedge clk) disable iff (rst)
        complete_i |=> (st_q.done && !st_q.busy));

    // R5: an accepted issue marks busy and clears done
    a_r5_busy_after_issue: assert property (@(posedge clk) disable iff (rst)
        issue_acc_i |=> (st_q.busy && !st_q.done));

    // R6: a stray completion while idle raises error
    a_r6_err_set: assert property (@(posedge clk) disable iff (rst)
        (idle_i && cu_done_i) |=> st_q.error);

endmodule

// File: rtl/ext_mem_arb.sv
module ext_mem_arb #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              op_running_i,
    input  logic              concurrent_i,
    input  logic              core_req_i,
    input  logic              core_we_i,
    input  logic [ADDR_W-1:0] core_addr_i,
    input  logic [DATA_W-1:0] core_wdata_i,
    input  logic              cu_req_i,
    input  logic              cu_we_i,
    input  logic [ADDR_W-1:0] cu_addr_i,
    input  logic [DATA_W-1:0] cu_wdata_i,
    output logic              core_gnt_o,
    output logic              cu_gnt_o,
    output logic              contention_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o
);

    logic core_allowed;

    assign core_allowed = !op_running_i || concurrent_i;
    assign cu_gnt_o     = op_running_i && cu_req_i;
    assign core_gnt_o   = core_req_i && core_allowed && !cu_gnt_o;
    assign contention_o = cu_gnt_o && core_req_i;

    always_comb begin
        mem_req_o   = cu_gnt_o || core_gnt_o;
        mem_we_o    = 1'b0;
        mem_addr_o  = core_addr_i;
        mem_wdata_o = core_wdata_i;
        if (cu_gnt_o) begin
            mem_we_o    = cu_we_i;
            mem_addr_o  = cu_addr_i;
            mem_wdata_o = cu_wdata_i;
        end else if (core_gnt_o) begin
            mem_we_o    = core_we_i;
        end
    end

endmodule

// File: rtl/ext_op_exec_ctrl.sv
module ext_op_exec_ctrl
    import ext_exec_pkg::*;
#(
    parameter int SLOT_W = 3,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              issue_i,
    input  logic [SLOT_W-1:0] issue_slot_i,
    output logic [SLOT_W-1:0] desc_slot_o,
    input  logic [DESC_W-1:0] desc_i,
    output logic              cu_start_o,
    input  logic              cu_done_i,
    output logic              core_stall_o,
    input  logic              irq_req_i,
    output logic              irq_core_o,
    output logic [2:0]        status_o,
    input  logic              core_mem_req_i,
    input  logic              core_mem_we_i,
    input  logic [ADDR_W-1:0] core_mem_addr_i,
    input  logic [DATA_W-1:0] core_mem_wdata_i,
    output logic              core_mem_gnt_o,
    output logic [DATA_W-1:0] core_mem_rdata_o,
    input  logic              cu_mem_req_i,
    input  logic              cu_mem_we_i,
    input  logic [ADDR_W-1:0] cu_mem_addr_i,
    input  logic [DATA_W-1:0] cu_mem_wdata_i,
    output logic              cu_mem_gnt_o,
    output logic [DATA_W-1:0] cu_mem_rdata_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    input  logic [DATA_W-1:0] mem_rdata_i
);

    exec_state_t seq_state;
    op_desc_t    cur_desc;
    op_status_t  stat;
    logic        issue_acc, op_complete, op_running, contention;

    assign desc_slot_o = issue_slot_i;

    ext_exec_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .issue_i     (issue_i),
        .desc_i      (op_desc_t'(desc_i)),
        .cu_done_i   (cu_done_i),
        .state_o     (seq_state),
        .desc_o      (cur_desc),
        .issue_acc_o (issue_acc),
        .complete_o  (op_complete),
        .cu_start_o  (cu_start_o)
    );

    ext_exec_status u_status (
        .clk         (clk),
        .rst         (rst),
        .issue_acc_i (issue_acc),
        .complete_i  (op_complete),
        .idle_i      (seq_state == ST_IDLE),
        .cu_done_i   (cu_done_i),
        .status_o    (stat)
    );

    assign op_running = (seq_state == ST_START) || (seq_state == ST_WAIT);

    ext_mem_arb #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arb (
        .op_running_i (op_running),
        .concurrent_i (cur_desc.concurrent),
        .core_req_i   (core_mem_req_i),
        .core_we_i    (core_mem_we_i),
        .core_addr_i  (core_mem_addr_i),
        .core_wdata_i (core_mem_wdata_i),
        .cu_req_i     (cu_mem_req_i),
        .cu_we_i      (cu_mem_we_i),
        .cu_addr_i    (cu_mem_addr_i),
        .cu_wdata_i   (cu_mem_wdata_i),
        .core_gnt_o   (core_mem_gnt_o),
        .cu_gnt_o     (cu_mem_gnt_o),
        .contention_o (contention),
        .mem_req_o    (mem_req_o),
        .mem_we_o     (mem_we_o),
        .mem_addr_o   (mem_addr_o),
        .mem_wdata_o  (mem_wdata_o)
    );

    assign core_mem_rdata_o = mem_rdata_i;
    assign cu_mem_rdata_o   = mem_rdata_i;

    assign core_stall_o = op_running && (!cur_desc.concurrent || contention);
    assign irq_core_o   = irq_req_i && !(op_running && cur_desc.irq_block);
    assign status_o     = stat;

    // R2: stall and interrupt mask are released in the finishing cycle
    a_r2_release_in_finish: assert property (@(posedge clk) disable iff (rst)
        (seq_state == ST_FINISH) |-> (!core_stall_o && (irq_core_o == irq_req_i)));

    // R4: a waiting operation with interrupt block never lets an interrupt through
    a_r4_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (seq_state == ST_WAIT && cur_desc.irq_block) |-> !irq_core_o);

    // R7: at most one side owns the memory port in any cycle
    a_r7_single_grant: assert property (@(posedge clk) disable iff (rst)
        $onehot0({core_mem_gnt_o, cu_mem_gnt_o}));

    // R8: a running unit request takes the port with its own address
    a_r8_cu_owns_port: assert property (@(posedge clk) disable iff (rst)
        (op_running && cu_mem_req_i) |-> (mem_req_o && mem_addr_o == cu_mem_addr_i && !core_mem_gnt_o));

    // R10: the idle controller never stalls the core
    a_r10_idle_no_stall: assert property (@(posedge clk) disable iff (rst)
        (seq_state == ST_IDLE) |-> (!core_stall_o && !cu_start_o));

endmodule

// File: tb/ext_op_exec_ctrl_tb_top.sv
`timescale 1ns/1ps
module ext_op_exec_ctrl_tb_top;

    localparam int SLOT_W = 3;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              issue_i = 1'b0;
    logic [SLOT_W-1:0] issue_slot_i = '0;
    logic [SLOT_W-1:0] desc_slot_o;
    logic [10:0]       desc_i = '0;
    logic              cu_start_o;
    logic              cu_done_i = 1'b0;
    logic              core_stall_o;
    logic              irq_req_i = 1'b0;
    logic              irq_core_o;
    logic [2:0]        status_o;
    logic              core_mem_req_i = 1'b0, core_mem_we_i = 1'b0;
    logic [ADDR_W-1:0] core_mem_addr_i = '0;
    logic [DATA_W-1:0] core_mem_wdata_i = '0;
    logic              core_mem_gnt_o;
    logic [DATA_W-1:0] core_mem_rdata_o;
    logic              cu_mem_req_i = 1'b0, cu_mem_we_i = 1'b0;
    logic [ADDR_W-1:0] cu_mem_addr_i = '0;
    logic [DATA_W-1:0] cu_mem_wdata_i = '0;
    logic              cu_mem_gnt_o;
    logic [DATA_W-1:0] cu_mem_rdata_o;
    logic              mem_req_o, mem_we_o;
    logic [ADDR_W-1:0] mem_addr_o;
    logic [DATA_W-1:0] mem_wdata_o;
    logic [DATA_W-1:0] mem_rdata_i = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ext_op_exec_ctrl #(.SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // bit 10 concurrent, bit 9 irq block, bits 8:1 latency, bit 0 latency valid
    function automatic logic [10:0] mk_desc(input logic lv, input logic [7:0] lat,
                                            input logic irqb, input logic conc);
        return {conc, irqb, lat, lv};
    endfunction

    // Issue in the current cycle; returns in the cycle after issue (first running cycle).
    task automatic do_issue(input logic [10:0] d);
        issue_i = 1'b1;
        desc_i  = d;
        tick();
        issue_i = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        irq_req_i = 1'b1;
        tick(); tick();
        rst = 1'b0;
        #1;
        chk("R10 stall after reset", core_stall_o, 0);
        chk("R10 start after reset", cu_start_o, 0);
        chk("R10 status after reset", status_o, 0);
        chk("R10 irq pass-through", irq_core_o, 1);
        irq_req_i = 1'b0;
    endtask

    task automatic t_slot();
        issue_slot_i = 3'd5;
        #1;
        chk("R9 slot lookup", desc_slot_o, 5);
        issue_slot_i = 3'd2;
        #1;
        chk("R9 slot lookup", desc_slot_o, 2);
    endtask

    task automatic t_fixed(input int lat, input logic irqb);
        int n = 0;
        int expn = (lat < 1) ? 1 : lat;
        irq_req_i = 1'b1;
        do_issue(mk_desc(1'b1, 8'(lat), irqb, 1'b0));
        chk("R1 start strobe", cu_start_o, 1);
        chk("R5 busy after issue", status_o, 3'b001);
        while (core_stall_o && n < 300) begin
            n++;
            if (irqb) chk("R4 irq masked", irq_core_o, 0);
            tick();
            if (n == 1) chk("R1 start is one cycle", cu_start_o, 0);
        end
        chk("R2 fixed stall length", n, expn);
        chk("R5 done at completion", status_o, 3'b010);
        chk("R4 mask released in finish", irq_core_o, 1);
        irq_req_i = 1'b0;
        tick();
    endtask

    task automatic t_handshake(input int k);
        int n = 0;
        do_issue(mk_desc(1'b0, 8'd2, 1'b0, 1'b0));
        while (core_stall_o && n < 300) begin
            n++;
            cu_done_i = (n == k);
            tick();
            cu_done_i = 1'b0;
        end
        chk("R3 handshake stall length", n, k);
        chk("R6 no error for in-op completion", status_o, 3'b010);
        tick();
    endtask

    task automatic t_error();
        cu_done_i = 1'b1;
        tick();
        cu_done_i = 1'b0;
        chk("R6 error set by idle completion", status_o[2], 1);
        tick();
        chk("R6 error sticky", status_o[2], 1);
        do_issue(mk_desc(1'b1, 8'd2, 1'b0, 1'b0));
        chk("R6 error cleared by issue", status_o, 3'b001);
        tick(); tick(); tick();
    endtask

    task automatic t_concurrent();
        int n = 0;
        do_issue(mk_desc(1'b1, 8'd6, 1'b0, 1'b1));
        chk("R7 concurrent no stall", core_stall_o, 0);
        core_mem_req_i = 1'b1; core_mem_addr_i = 16'h1111;
        cu_mem_req_i   = 1'b1; cu_mem_addr_i   = 16'h2222;
        #1;
        chk("R7 contention stall", core_stall_o, 1);
        chk("R7 unit granted", cu_mem_gnt_o, 1);
        chk("R7 core refused", core_mem_gnt_o, 0);
        chk("R7 unit address", mem_addr_o, 16'h2222);
        tick();
        cu_mem_req_i = 1'b0;
        #1;
        chk("R7 core alone not stalled", core_stall_o, 0);
        chk("R7 core granted", core_mem_gnt_o, 1);
        chk("R7 core address", mem_addr_o, 16'h1111);
        core_mem_req_i = 1'b0;
        while (status_o[0] && n < 300) begin n++; tick(); end
        chk("R7 concurrent completion time", n + 2, 7);
        chk("R7 concurrent done", status_o, 3'b010);
        tick();
    endtask

    task automatic t_memroute();
        int n = 0;
        do_issue(mk_desc(1'b1, 8'd4, 1'b0, 1'b0));
        cu_mem_req_i = 1'b1; cu_mem_we_i = 1'b1; cu_mem_addr_i = 16'h0ABC;
        cu_mem_wdata_i = 32'hDEAD_BEEF;
        core_mem_req_i = 1'b1; core_mem_addr_i = 16'h0F00; core_mem_we_i = 1'b0;
        mem_rdata_i = 32'h1234_5678;
        #1;
        chk("R8 unit request on port", mem_req_o, 1);
        chk("R8 unit address", mem_addr_o, 16'h0ABC);
        chk("R8 unit write enable", mem_we_o, 1);
        chk("R8 unit write data", mem_wdata_o, 32'hDEAD_BEEF);
        chk("R8 unit read data", cu_mem_rdata_o, 32'h1234_5678);
        chk("R8 core no grant", core_mem_gnt_o, 0);
        cu_mem_req_i = 1'b0;
        #1;
        chk("R8 core no grant while running", core_mem_gnt_o, 0);
        chk("R8 port idle", mem_req_o, 0);
        while (core_stall_o && n < 300) begin n++; tick(); end
        cu_mem_req_i = 1'b1;
        #1;
        chk("R8 unit refused when not running", cu_mem_gnt_o, 0);
        chk("R8 core granted when not running", core_mem_gnt_o, 1);
        chk("R8 core address when not running", mem_addr_o, 16'h0F00);
        cu_mem_req_i = 1'b0; cu_mem_we_i = 1'b0; core_mem_req_i = 1'b0;
        tick();
    endtask

    task automatic t_ignore();
        int n = 0;
        do_issue(mk_desc(1'b1, 8'd3, 1'b0, 1'b0));
        issue_i = 1'b1;
        desc_i  = mk_desc(1'b1, 8'd20, 1'b0, 1'b0);
        while (core_stall_o && n < 300) begin n++; tick(); end
        chk("R1 issue during op ignored", n, 3);
        tick();
        chk("R1 issue in finish ignored (stall)", core_stall_o, 0);
        chk("R1 issue in finish ignored (status)", status_o, 3'b010);
        issue_i = 1'b0;
        tick();
    endtask

    initial begin
        t_reset();
        t_slot();
        t_fixed(0, 1'b0);
        t_fixed(1, 1'b1);
        t_fixed(5, 1'b1);
        t_handshake(1);
        t_handshake(4);
        t_error();
        t_concurrent();
        t_memroute();
        t_ignore();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(5 * 100000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule